// File: doc/BRIEF.md
# Comparator Bus Conditioning and Logic Combiner

This block takes the raw outputs of a row of analog comparators, one per column, and prepares them for digital consumers. Each column's bit either passes through a two-flop synchronizer that advances on that column's clock strobe, or goes straight through when the column is set to bypass. The conditioned bit is the readable status for that column.

The conditioned bit can then be qualified by a gate. The gate is either one selected output from a vector of digital-block outputs or, when the dedicated PWM path is enabled, the PWM signal, which takes precedence. This lets a counter see the comparator only inside a chosen window, as a single-slope converter needs. Gating is switched on per column. Finally, each column has a two-input programmable logic function with a 4-bit code. It mixes its own gated bit with its neighbour's gated bit; the last column receives a constant zero as its second operand.

Column clocks arrive as single-cycle strobes on the system clock, so the whole block sits in one clock domain.

Top module: `cmpbus_cond`

## Requirements
- R1: With bypass clear for column i, `cmp_status[i]` equals the value `cmp_raw[i]` held at the second-most-recent clock edge where `col_tick[i]` was high. It changes only in a cycle that follows a tick of that column.
- R2: With `cfg_bypass[i]` set, `cmp_status[i]` equals `cmp_raw[i]` in the same cycle.
- R3: With `cfg_gate_en[i]` set and `cfg_pwm_en` clear, `cmp_gated[i]` equals `cmp_status[i]` AND `dig_out[cfg_gate_sel]`.
- R4: With `cfg_gate_en[i]` clear, `cmp_gated[i]` equals `cmp_status[i]`, whatever the gate sources hold.
- R5: With `cfg_pwm_en` set, the gate for every gated column is `pwm_gate`. `dig_out` and `cfg_gate_sel` then have no effect on `cmp_gated`.
- R6: Column i's function code is `cfg_lut_fn[4*i+3:4*i]`. `lut_out[i]` is the code bit at index 2*(NOT A)+(NOT B). This makes code 0 FALSE, 1 AND, 3 A, 5 B, 6 XOR, 7 OR, 8 NOR, 9 XNOR, A NOT B, C NOT A, E NAND and F TRUE.
- R7: Column i's operand A is `cmp_gated[i]`. Its operand B is `cmp_gated[i+1]`, or constant 0 for the last column.
- R8: After reset, both synchronizer stages of every column are 0, so a column in synchronized mode reads status 0 until its second tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_tick | input | NCOL | Per-column clock strobe, one cycle wide |
| cmp_raw | input | NCOL | Raw comparator bits |
| dig_out | input | NDIG | Digital-block primary outputs usable as gate |
| pwm_gate | input | 1 | Dedicated converter PWM gate |
| cfg_bypass | input | NCOL | Per-column synchronizer bypass |
| cfg_gate_en | input | NCOL | Per-column gating enable |
| cfg_gate_sel | input | SEL_W | Index of the digital-block gate source |
| cfg_pwm_en | input | 1 | PWM gate overrides the digital-block selection |
| cfg_lut_fn | input | 4*NCOL | Per-column 4-bit logic function codes |
| cmp_status | output | NCOL | Conditioned, readable comparator bits |
| cmp_gated | output | NCOL | Gated comparator bus |
| lut_out | output | NCOL | Logic function results |

## Verification
On every cycle, the assertions check the following:
- A synchronized status holds steady without a tick.
- A bypassed status tracks its raw input.
- A low PWM or a low selected digital output forces gated columns low.
- Codes 0 and F give constant results.
- The last column sees B as zero.

Two things only the bench's scenarios can show, by comparing against a cycle-level model through long random runs and a code sweep. One is that the synchronizer really delays by two ticks, not one or three. The other is that every one of the sixteen codes maps to the right truth table with the right operand order.

// File: rtl/cmpbus_pkg.sv
package cmpbus_pkg;

    localparam int unsigned FN_W = 4;

    typedef struct packed {
        logic stage1;
        logic stage2;
    } sync_st_t;

    typedef logic [FN_W-1:0] lut_fn_t;

endpackage

// File: rtl/cmpbus_sync.sv
module cmpbus_sync
    import cmpbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    input  logic bypass,
    output logic status
);

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.stage1 = raw;
            st_d.stage2 = st_q.stage1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = bypass ? raw : st_q.stage2;

    assert_sync_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bypass) |=> (bypass || $stable(status)));

    assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (status == raw));

endmodule

// File: rtl/cmpbus_gate.sv
module cmpbus_gate #(
    parameter int unsigned NDIG  = 8,
    localparam int unsigned SEL_W = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NDIG-1:0]  dig_out,
    input  logic [SEL_W-1:0] sel,
    input  logic             pwm_en,
    input  logic             pwm_gate,
    output logic             gate
);

    logic dig_pick;

    always_comb begin
        dig_pick = 1'b0;
        for (int k = 0; k < NDIG; k++) begin
            if (sel == SEL_W'(k)) dig_pick = dig_out[k];
        end
        gate = pwm_en ? pwm_gate : dig_pick;
    end

    assert_pwm_low_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && !pwm_gate) |-> !gate);

endmodule

// File: rtl/cmpbus_lut.sv
module cmpbus_lut
    import cmpbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  lut_fn_t fn,
    input  logic    op_a,
    input  logic    op_b,
    output logic    result
);

    logic [1:0] idx;

    always_comb begin
        idx    = {~op_a, ~op_b};
        result = fn[idx];
    end

    assert_lut_false_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 4'h0) |-> !result);

    assert_lut_true_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 4'hF) |-> result);

endmodule

// File: rtl/cmpbus_cond.sv
module cmpbus_cond
    import cmpbus_pkg::*;
#(
    parameter int unsigned NCOL  = 2,
    parameter int unsigned NDIG  = 8,
    localparam int unsigned SEL_W = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCOL-1:0]      col_tick,
    input  logic [NCOL-1:0]      cmp_raw,
    input  logic [NDIG-1:0]      dig_out,
    input  logic                 pwm_gate,
    input  logic [NCOL-1:0]      cfg_bypass,
    input  logic [NCOL-1:0]      cfg_gate_en,
    input  logic [SEL_W-1:0]     cfg_gate_sel,
    input  logic                 cfg_pwm_en,
    input  logic [FN_W*NCOL-1:0] cfg_lut_fn,
    output logic [NCOL-1:0]      cmp_status,
    output logic [NCOL-1:0]      cmp_gated,
    output logic [NCOL-1:0]      lut_out
);

    logic gate;

    cmpbus_gate #(.NDIG(NDIG)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .dig_out  (dig_out),
        .sel      (cfg_gate_sel),
        .pwm_en   (cfg_pwm_en),
        .pwm_gate (pwm_gate),
        .gate     (gate)
    );

    for (genvar i = 0; i < NCOL; i++) begin : g_col
        logic op_b;

        cmpbus_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (col_tick[i]),
            .raw    (cmp_raw[i]),
            .bypass (cfg_bypass[i]),
            .status (cmp_status[i])
        );

        assign cmp_gated[i] = cfg_gate_en[i] ? (cmp_status[i] & gate) : cmp_status[i];

        if (i == NCOL - 1) begin : g_last
            assign op_b = 1'b0;
        end else begin : g_mid
            assign op_b = cmp_gated[i+1];
        end

        cmpbus_lut u_lut (
            .clk    (clk),
            .rst_n  (rst_n),
            .fn     (cfg_lut_fn[FN_W*i +: FN_W]),
            .op_a   (cmp_gated[i]),
            .op_b   (op_b),
            .result (lut_out[i])
        );

        assert_ungated_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_gate_en[i] |-> (cmp_gated[i] == cmp_status[i]));

        assert_gated_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_gate_en[i] && !cfg_pwm_en && !dig_out[cfg_gate_sel]) |-> !cmp_gated[i]);
    end

    assert_last_b_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lut_fn[FN_W*(NCOL-1) +: FN_W] == 4'h5) |-> !lut_out[NCOL-1]);

endmodule

// File: tb/test_cmpbus_cond.sv
module test_cmpbus_cond;

    localparam int NCOL  = 2;
    localparam int NDIG  = 8;
    localparam int SEL_W = 3;
    localparam int LIMIT = 100000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCOL-1:0]      col_tick = '0;
    logic [NCOL-1:0]      cmp_raw = '0;
    logic [NDIG-1:0]      dig_out = '0;
    logic                 pwm_gate = 1'b0;
    logic [NCOL-1:0]      cfg_bypass = '0;
    logic [NCOL-1:0]      cfg_gate_en = '0;
    logic [SEL_W-1:0]     cfg_gate_sel = '0;
    logic                 cfg_pwm_en = 1'b0;
    logic [4*NCOL-1:0]    cfg_lut_fn = '0;
    logic [NCOL-1:0]      cmp_status, cmp_gated, lut_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // model: per-column history of raw bits captured on ticks
    bit hist1 [NCOL];
    bit hist2 [NCOL];

    always #4 clk = ~clk;

    cmpbus_cond #(.NCOL(NCOL), .NDIG(NDIG)) i_cmpbus_cond (
        .clk(clk), .rst_n(rst_n), .col_tick(col_tick), .cmp_raw(cmp_raw),
        .dig_out(dig_out), .pwm_gate(pwm_gate), .cfg_bypass(cfg_bypass),
        .cfg_gate_en(cfg_gate_en), .cfg_gate_sel(cfg_gate_sel),
        .cfg_pwm_en(cfg_pwm_en), .cfg_lut_fn(cfg_lut_fn),
        .cmp_status(cmp_status), .cmp_gated(cmp_gated), .lut_out(lut_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        for (int i = 0; i < NCOL; i++) begin
            if (!rst_n) begin
                hist1[i] <= 0;
                hist2[i] <= 0;
            end else if (col_tick[i]) begin
                hist2[i] <= hist1[i];
                hist1[i] <= cmp_raw[i];
            end
        end
    end

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    function automatic bit exp_status(input int i);
        return cfg_bypass[i] ? cmp_raw[i] : hist2[i];
    endfunction

    function automatic bit exp_gate();
        return cfg_pwm_en ? pwm_gate : dig_out[cfg_gate_sel];
    endfunction

    function automatic bit exp_gated(input int i);
        bit s = exp_status(i);
        if (!cfg_gate_en[i]) return s;
        return s && exp_gate();
    endfunction

    function automatic bit exp_lut(input int i);
        bit a = exp_gated(i);
        bit b = (i == NCOL - 1) ? 1'b0 : exp_gated(i + 1);
        int idx = (a ? 0 : 2) + (b ? 0 : 1);
        bit [3:0] fn = cfg_lut_fn[4*i +: 4];
        return fn[idx];
    endfunction

    task automatic compare_all();
        for (int i = 0; i < NCOL; i++) begin
            check_bit(cfg_bypass[i] ? "R2" : "R1", $sformatf("status[%0d]", i), cmp_status[i], exp_status(i));
            check_bit(!cfg_gate_en[i] ? "R4" : (cfg_pwm_en ? "R5" : "R3"),
                      $sformatf("gated[%0d]", i), cmp_gated[i], exp_gated(i));
            check_bit(i == NCOL - 1 ? "R7" : "R6", $sformatf("lut[%0d]", i), lut_out[i], exp_lut(i));
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        while (cycles < LIMIT && !finished) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        cmp_raw = '1;
        col_tick = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset clears stages; raw=1 with ticks, so status is 0 now and 1 after two ticks
        @(negedge clk);
        check_bit("R8", "status0 after one tick", cmp_status[0], 1'b0);
        check_bit("R8", "status1 after one tick", cmp_status[1], 1'b0);
        @(negedge clk);
        check_bit("R1", "status0 after two ticks", cmp_status[0], 1'b1);
        col_tick = '0;

        // R1: no ticks -> status holds while raw toggles
        cmp_raw = '0;
        repeat (4) step();
        check_bit("R1", "status0 held without tick", cmp_status[0], 1'b1);

        // R2: bypass follows raw immediately
        cfg_bypass = '1;
        cmp_raw = 2'b01;
        #1 check_bit("R2", "bypass status0", cmp_status[0], 1'b1);
        check_bit("R2", "bypass status1", cmp_status[1], 1'b0);

        // R6/R7: sweep all codes and operand combinations in bypass, no gating
        for (int code = 0; code < 16; code++) begin
            for (int ab = 0; ab < 4; ab++) begin
                cfg_lut_fn = {4'(code), 4'(code)};
                cmp_raw = 2'(ab);
                step();
            end
        end
        cfg_lut_fn = {4'h5, 4'h6};
        cmp_raw = 2'b11;
        #1 check_bit("R6", "XOR of 1,1", lut_out[0], 1'b0);
        check_bit("R7", "last column B is zero", lut_out[1], 1'b0);

        // R3/R5: gating with digital source then pwm override
        cfg_gate_en = 2'b01;
        cfg_gate_sel = 3'd5;
        dig_out = 8'h20;
        #1 check_bit("R3", "gate open via dig_out[5]", cmp_gated[0], 1'b1);
        dig_out = 8'hDF;
        #1 check_bit("R3", "gate closed via dig_out[5]", cmp_gated[0], 1'b0);
        check_bit("R4", "ungated column passes", cmp_gated[1], 1'b1);
        cfg_pwm_en = 1'b1;
        pwm_gate = 1'b1;
        #1 check_bit("R5", "pwm overrides closed dig gate", cmp_gated[0], 1'b1);
        dig_out = 8'hFF;
        pwm_gate = 1'b0;
        #1 check_bit("R5", "dig_out ignored under pwm", cmp_gated[0], 1'b0);

        // random run, compared every cycle
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            compare_all();
            col_tick = 2'($urandom);
            cmp_raw = 2'($urandom);
            dig_out = 8'($urandom);
            pwm_gate = 1'($urandom);
            if (n % 37 == 0) begin
                cfg_bypass = 2'($urandom);
                cfg_gate_en = 2'($urandom);
                cfg_gate_sel = 3'($urandom);
                cfg_pwm_en = 1'($urandom);
                cfg_lut_fn = 8'($urandom);
            end
        end
        step();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule